// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block stores incoming frames into a ring of 256-byte pages in local memory. A page number is the upper byte of a 16-bit memory address and the offset within the page is the lower byte. The ring covers every page from the start page up to, but not including, the stop page. The host sets both bounds, and it also owns a boundary page: the oldest page it has not yet read.

Each frame arrives as a byte stream. The data bytes go into memory straight away, beginning at offset 4 of the current page, so that four bytes are left free for a header. The header is written only once the frame has ended and its length and status are known. It then holds the status byte, the page where the next frame will start, and the stored count. After the header is written, the current-page pointer moves on to that next page. Frames in monitor mode, frames that would run into the boundary page, and frames marked bad at their last byte never receive a header and leave the current page unchanged. The first two kinds are reported as missed.

The host must leave at least four idle cycles after the last byte of a frame, so that the header can be written.

Top module: `rx_ring_mgr`

## Requirements
- R1: While reset is held and in the cycle after it is released, `curr_page` is 0 and `mem_we`, `missed` and `ovw` are all 0.
- R2: Data byte k of a frame (k counts from 0) is written at the point 4+k bytes past the start of the current page. Writing runs upward through the page and carries on into the next ring page after offset 255.
- R3: The page that follows page P is `pstart` when P+1 equals `pstop`, and P+1 otherwise. No write ever lands outside the pages from `pstart` to `pstop`-1.
- R4: For an accepted frame of L bytes, four header bytes follow the last data byte at offsets 0, 1, 2 and 3 of the frame's first page. In order they are: the `rx_status` byte sampled with the last data byte, the next page, the low byte of L+4, and the high byte of L+4.
- R5: When a frame is accepted, `curr_page` becomes the page after the last page that holds any of the frame's bytes, counting the 4-byte header as part of the frame. This change appears in the cycle after the fourth header write.
- R6: If the frame would enter the boundary page (`bnry`), `ovw` and `missed` are both raised. This includes the case where the frame's next page would be the boundary page. Bytes that would fall in or past the boundary page are not written, no header is written, and `curr_page` keeps its value.
- R7: When `monitor` is high at the first byte of a frame, none of that frame's bytes are written and no header is written. `missed` is raised, `ovw` stays 0, and `curr_page` keeps its value.
- R8: A frame with `rx_bad` high at its last byte gets no header. `curr_page` keeps its value, and neither `missed` nor `ovw` is raised.
- R9: A pulse on `curr_ld` between frames loads `curr_wdata` into `curr_page` on the next clock edge.
- R10: `missed` and `ovw` are pulses one cycle wide. They are high in the cycle that immediately follows the clock edge on which the frame's last byte is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pstart | input | 8 | First page of the ring |
| pstop | input | 8 | Page just past the end of the ring |
| bnry | input | 8 | Oldest page not yet read by the host |
| monitor | input | 1 | Check frames but do not store them |
| curr_ld | input | 1 | Load the current-page pointer |
| curr_wdata | input | 8 | Value loaded into the current-page pointer |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_bad | input | 1 | The frame is errored (sampled with the last byte) |
| rx_status | input | 8 | Status byte for the header (sampled with the last byte) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address: page number in the upper byte |
| mem_wdata | output | 8 | Memory write data |
| curr_page | output | 8 | Page where the next frame will start |
| ovw | output | 1 | Pulse: the frame ran into the boundary page |
| missed | output | 1 | Pulse: the frame was not stored |

## Verification
The bench sweeps a 4-page ring over frame lengths that end just before, exactly on, and just past a page edge. For each length it puts the boundary at every possible distance from the current page, and it starts frames on every page so that wrap-around is covered.

Each of these cases catches a specific fault:
- An off-by-one in the full check would either store a frame whose next page equals the boundary, or refuse one that fits.
- A wrong next-page value would show when a frame ends exactly at offset 255.
- A count with its bytes swapped, or without the 4 added, would show in the header comparison.
- A wrap taken at the stop page instead of before it would write outside the ring.

Monitor frames and errored frames are interleaved with good ones. A design that still wrote a header for them, or moved its pointer, would corrupt the expected pointer for every frame that follows.

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  pstart,
  input  logic [7:0]  pstop,
  input  logic [7:0]  bnry,
  input  logic        monitor,
  input  logic        curr_ld,
  input  logic [7:0]  curr_wdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_bad,
  input  logic [7:0]  rx_status,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic [7:0]  curr_page,
  output logic        ovw,
  output logic        missed
);
  logic [7:0]  curr_q, pg_q, off_q, next_q, stat_q;
  logic [15:0] n_q, cnt_q;
  logic        act_q, full_q, mon_q, hdr_q, ovw_q, miss_q;
  logic [1:0]  hi_q;

  logic [7:0]  pg_c, off_c, pg_inc, pg_n, off_n, pgn_inc, nxt, hbyte;
  logic [15:0] n_c, n_n;
  logic        full_c, mon_c, take, store, full_n, end_full;

  assign pg_c    = act_q ? pg_q : curr_q;
  assign off_c   = act_q ? off_q : 8'd4;
  assign n_c     = act_q ? n_q : 16'd0;
  assign full_c  = act_q & full_q;
  assign mon_c   = act_q ? mon_q : monitor;
  assign take    = rx_valid & ~hdr_q;
  assign store   = take & ~full_c & ~mon_c;

  assign pg_inc  = (pg_c + 8'd1 == pstop) ? pstart : pg_c + 8'd1;
  assign off_n   = off_c + 8'd1;
  assign pg_n    = (off_c == 8'hff) ? pg_inc : pg_c;
  assign full_n  = full_c | (~mon_c & (off_c == 8'hff) & (pg_inc == bnry));
  assign pgn_inc = (pg_n + 8'd1 == pstop) ? pstart : pg_n + 8'd1;
  assign nxt     = (off_n == 8'd0) ? pg_n : pgn_inc;
  assign end_full = full_n | (~mon_c & (off_n != 8'd0) & (pgn_inc == bnry));
  assign n_n     = n_c + 16'd1;

  always_comb begin
    case (hi_q)
      2'd0:    hbyte = stat_q;
      2'd1:    hbyte = next_q;
      2'd2:    hbyte = cnt_q[7:0];
      default: hbyte = cnt_q[15:8];
    endcase
  end

  assign mem_we    = store | hdr_q;
  assign mem_addr  = hdr_q ? {curr_q, 6'd0, hi_q} : {pg_c, off_c};
  assign mem_wdata = hdr_q ? hbyte : rx_data;
  assign curr_page = curr_q;
  assign ovw       = ovw_q;
  assign missed    = miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curr_q <= '0; pg_q <= '0; off_q <= '0; next_q <= '0; stat_q <= '0;
      n_q <= '0; cnt_q <= '0; hi_q <= '0;
      act_q <= 1'b0; full_q <= 1'b0; mon_q <= 1'b0; hdr_q <= 1'b0;
      ovw_q <= 1'b0; miss_q <= 1'b0;
    end else begin
      ovw_q  <= 1'b0;
      miss_q <= 1'b0;
      if (hdr_q) begin
        hi_q <= hi_q + 2'd1;
        if (hi_q == 2'd3) begin
          hdr_q  <= 1'b0;
          curr_q <= next_q;
        end
      end else if (take) begin
        if (rx_last) begin
          act_q <= 1'b0;
          if (!rx_bad) begin
            if (mon_c | end_full) begin
              miss_q <= 1'b1;
              ovw_q  <= end_full;
            end else begin
              hdr_q  <= 1'b1;
              hi_q   <= 2'd0;
              next_q <= nxt;
              stat_q <= rx_status;
              cnt_q  <= n_n + 16'd4;
            end
          end
        end else begin
          act_q  <= 1'b1;
          pg_q   <= pg_n;
          off_q  <= off_n;
          n_q    <= n_n;
          full_q <= full_n;
          mon_q  <= mon_c;
        end
      end else if (curr_ld && !act_q) begin
        curr_q <= curr_wdata;
      end
    end
  end
endmodule

module rx_ring_mgr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  pstart,
  input logic [7:0]  pstop,
  input logic        curr_ld,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  curr_page,
  input logic        ovw,
  input logic        missed
);
  assert_wr_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] >= pstart && mem_addr[15:8] < pstop));

  assert_ovw_is_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovw |-> missed);

  assert_hdr_before_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(curr_page) && !$past(curr_ld)) |->
      ($past(mem_we) && $past(mem_addr) == {$past(curr_page), 8'd3}));

  assert_next_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == {curr_page, 8'd1}) |->
      (mem_wdata >= pstart && mem_wdata < pstop));
endmodule

bind rx_ring_mgr rx_ring_mgr_chk u_chk (.*);

// File: tb/rx_ring_mgr_test.sv
`timescale 1ns/1ps
module rx_ring_mgr_test;
  localparam int PS = 16;
  localparam int PE = 20;
  localparam int RP = PE - PS;

  logic clk = 1'b0;
  logic rst_n, monitor, curr_ld, rx_valid, rx_last, rx_bad;
  logic [7:0] pstart, pstop, bnry, curr_wdata, rx_data, rx_status;
  logic mem_we, ovw, missed;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, curr_page;

  always #2.5 clk = ~clk;

  rx_ring_mgr uut (.*);

  logic [7:0] mem [0:1023];
  int tag [0:1023];
  int cur_id = 0, wr_cnt = 0, miss_cnt = 0, ovw_cnt = 0, oor_cnt = 0;
  int total = 0, fails = 0, exp_curr = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      wr_cnt++;
      if (mem_addr >= 16'h1000 && mem_addr < 16'h1400) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        tag[mem_addr[9:0]] <= cur_id;
      end else oor_cnt++;
    end
    if (missed) miss_cnt++;
    if (ovw) ovw_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rstep(int p, int s);
    return PS + ((p - PS + s) % RP);
  endfunction

  function automatic int idx(int p, int off);
    return ((p - PS) << 8) + off;
  endfunction

  task automatic send(input int len, input bit bad, input bit mon, input int db);
    int c, d, u, dw, bad_bytes, nx;
    bit of, acc, expm;
    cur_id++;
    c = exp_curr;
    @(negedge clk);
    bnry = 8'(rstep(c, db));
    monitor = mon;
    wr_cnt = 0; miss_cnt = 0; ovw_cnt = 0;
    d = db == 0 ? RP : db;
    u = (len + 4 + 255) / 256;
    of = !mon && (u >= d);
    acc = !bad && !mon && !of;
    expm = !bad && (mon || of);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data = 8'((cur_id * 13 + k) & 255);
      rx_last = (k == len - 1);
      rx_bad = bad;
      rx_status = 8'(cur_id);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_bad = 1'b0;
    chk(missed == expm, "R10 missed pulse timing", int'(missed), int'(expm));
    repeat (7) @(negedge clk);
    monitor = 1'b0;
    dw = mon ? 0 : ((len < 256 * d - 4) ? len : 256 * d - 4);
    chk(wr_cnt == dw + (acc ? 4 : 0), "R2 R6 R7 write count", wr_cnt, dw + (acc ? 4 : 0));
    chk(miss_cnt == int'(expm), "R6 R7 R8 missed count", miss_cnt, int'(expm));
    chk(ovw_cnt == int'(!bad && of), "R6 ovw count", ovw_cnt, int'(!bad && of));
    chk(oor_cnt == 0, "R3 writes inside ring", oor_cnt, 0);
    bad_bytes = 0;
    for (int k = 0; k < dw; k++) begin
      int p = rstep(c, (4 + k) / 256);
      int i = idx(p, (4 + k) % 256);
      if (tag[i] != cur_id || mem[i] != 8'((cur_id * 13 + k) & 255)) bad_bytes++;
    end
    chk(bad_bytes == 0, "R2 R3 data placement", bad_bytes, 0);
    if (acc) begin
      nx = rstep(c, u);
      chk(tag[idx(c,0)] == cur_id && mem[idx(c,0)] == 8'(cur_id), "R4 header status", int'(mem[idx(c,0)]), cur_id & 255);
      chk(mem[idx(c,1)] == 8'(nx), "R4 header next page", int'(mem[idx(c,1)]), nx);
      chk(mem[idx(c,2)] == 8'((len + 4) & 255), "R4 header count low", int'(mem[idx(c,2)]), (len + 4) & 255);
      chk(mem[idx(c,3)] == 8'((len + 4) >> 8), "R4 header count high", int'(mem[idx(c,3)]), (len + 4) >> 8);
      exp_curr = nx;
    end
    chk(int'(curr_page) == exp_curr, "R5 R6 R7 R8 current page", int'(curr_page), exp_curr);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int lens [10] = '{1, 2, 251, 252, 253, 300, 508, 509, 764, 1000};
    rst_n = 1'b0; monitor = 1'b0; curr_ld = 1'b0; curr_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_bad = 1'b0; rx_status = '0;
    pstart = 8'(PS); pstop = 8'(PE); bnry = 8'(PS);
    repeat (3) @(negedge clk);
    chk(curr_page == 8'd0 && !mem_we && !missed && !ovw, "R1 in reset", int'(curr_page), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(curr_page == 8'd0 && !mem_we && !missed && !ovw, "R1 after reset", int'(curr_page), 0);
    curr_ld = 1'b1; curr_wdata = 8'(PS);
    @(negedge clk);
    curr_ld = 1'b0;
    exp_curr = PS;
    chk(int'(curr_page) == PS, "R9 pointer load", int'(curr_page), PS);

    for (int li = 0; li < 10; li++)
      for (int db = 0; db < RP; db++)
        send(lens[li], 1'b0, 1'b0, db);
    send(100, 1'b0, 1'b1, 0);
    send(700, 1'b0, 1'b1, 2);
    send(40, 1'b1, 1'b0, 0);
    send(600, 1'b1, 1'b0, 3);
    send(252, 1'b0, 1'b0, 0);

    @(negedge clk);
    curr_ld = 1'b1; curr_wdata = 8'(PS + 2);
    @(negedge clk);
    curr_ld = 1'b0;
    exp_curr = PS + 2;
    chk(int'(curr_page) == PS + 2, "R9 pointer reload", int'(curr_page), PS + 2);
    send(1020, 1'b0, 1'b0, 0);
    send(10, 1'b0, 1'b0, 3);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule